// File: doc/BRIEF.md
# Delta-Sigma Density DAC

This block turns a digital level into a one-bit stream whose share of ones tracks the level, ready to drive an external RC low-pass filter. The main path is a first-order delta-sigma loop. A register keeps the running sum modulo 2^WIDTH. Each cycle the level is added to that sum, and the adder's carry-out is the output bit. The carry spreads the ones as evenly as the level allows, which pushes the ripple to the highest frequency the level permits.

A mode input switches the output to a pulse-width modulator, so the two schemes can be compared on the same pin. The PWM path has a free-running counter and a compare against a shadow copy of the level. That copy is taken at reset and at each wrap of the counter. The PWM path therefore produces one contiguous high pulse per period. Both paths run all the time, and the mode input only selects which one reaches the pin.

Top module: `density_dac`

## Requirements
- R1: After synchronous reset the accumulator is zero. For a steady level L > 0 in delta-sigma mode, the first cycle after reset gives 0, and the first 1 appears in cycle number ceil(2^WIDTH / L), counting that first cycle as 1.
- R2: In delta-sigma mode with a steady level L, exactly L ones appear in the first 256 cycles after reset (WIDTH = 8). Over n cycles, floor(n*L/256) ones appear.
- R3: With a level of 128, the delta-sigma output changes value on every cycle.
- R4: With a level of 64, every window of four consecutive delta-sigma output cycles holds exactly one 1.
- R5: With a level of 192, every window of four consecutive delta-sigma output cycles holds exactly three 1s.
- R6: A level of 0 never produces a 1 in either mode.
- R7: In delta-sigma mode the output in each cycle is the carry of (held sum + current level). The held sum then becomes that sum modulo 256, even when the level changes from cycle to cycle.
- R8: In PWM mode the counter starts at 0 after reset and steps by one each cycle, wrapping after 255. The output is 1 while the count is below the captured level, which gives one high run of L cycles at the start of every 256-cycle period.
- R9: The PWM path captures the level during reset and on the cycle whose count is 255. A level change at any other point in a period has no effect until the next period.
- R10: Both paths advance on every cycle whatever the mode. Changing pwm_mode switches the output between the two running paths in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_mode | input | 1 | 0 selects the delta-sigma path, 1 selects the PWM path |
| level | input | WIDTH | Requested output density, in units of 1/2^WIDTH |
| dout | output | 1 | One-bit density stream |

## Verification
The bench aims at the extremes of the level range. A level of 1 must give a single 1 at cycle 256 and a level of 255 a single 0 at cycle 1. A design that clears the carry or loses it off by one would shift those positions or change the count. The regular levels 64, 128 and 192 are checked window by window, so a design that bunches its ones into one pulse, as a PWM does, is caught even when its average is right. In PWM mode the level is changed in the middle of a period. A design that fails to hold the shadow copy would show a pulse of the wrong length in that period. Toggling the mode mid-stream exposes a design that stalls the path that is not selected.

// File: rtl/dsdac_pkg.sv
package dsdac_pkg;
  typedef enum logic {
    SEL_SIGMA = 1'b0,
    SEL_PULSE = 1'b1
  } dac_sel_e;
endpackage

// File: rtl/dsdac_accum.sv
module dsdac_accum #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] HALF = WIDTH'(1) << (WIDTH - 1);

  function automatic logic [WIDTH:0] add_ext(input logic [WIDTH-1:0] a,
                                             input logic [WIDTH-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [WIDTH-1:0] acc_q;
  logic [WIDTH:0]   sum_w;

  assign sum_w   = add_ext(acc_q, level);
  assign carry_o = sum_w[WIDTH];

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= sum_w[WIDTH-1:0];
  end

  // R6
  zero_level_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> !carry_o);

  // R7
  carry_wraps_sum_chk: assert property (@(posedge clk) disable iff (rst)
    carry_o |=> (acc_q < $past(level)));

  // R3
  half_level_toggles_chk: assert property (@(posedge clk) disable iff (rst)
    (level == HALF && $past(level) == HALF && !$past(rst)) |-> (carry_o != $past(carry_o)));
endmodule

// File: rtl/dsdac_pwm.sv
module dsdac_pwm #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  output logic             high_o
);
  localparam logic [WIDTH-1:0] CNT_LAST = '1;

  function automatic logic below(input logic [WIDTH-1:0] cnt,
                                 input logic [WIDTH-1:0] thr);
    return cnt < thr;
  endfunction

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] shadow_q;
  logic             wrap_evt;

  assign wrap_evt = (cnt_q == CNT_LAST);
  assign high_o   = below(cnt_q, shadow_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      shadow_q <= level;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap_evt) shadow_q <= level;
    end
  end

  // R9
  shadow_held_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> $stable(shadow_q));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> !$rose(high_o));
endmodule

// File: rtl/density_dac.sv
module density_dac #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_mode,
  input  logic [WIDTH-1:0] level,
  output logic             dout
);
  import dsdac_pkg::*;

  dac_sel_e sel;
  logic     sigma_bit;
  logic     pulse_bit;

  assign sel = dac_sel_e'(pwm_mode);

  dsdac_accum #(.WIDTH(WIDTH)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .level   (level),
    .carry_o (sigma_bit)
  );

  dsdac_pwm #(.WIDTH(WIDTH)) u_pwm (
    .clk    (clk),
    .rst    (rst),
    .level  (level),
    .high_o (pulse_bit)
  );

  always_comb begin
    case (sel)
      SEL_PULSE: dout = pulse_bit;
      default:   dout = sigma_bit;
    endcase
  end

  // R6
  zero_level_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && $past(level) == '0 && !$past(rst) && !pwm_mode) |-> !dout);
endmodule

// File: tb/density_dac_test.sv
`timescale 1ns/1ps
module density_dac_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_mode = 1'b0;
  logic [7:0] level = 8'd0;
  logic       dout;

  always #4 clk = ~clk;

  density_dac #(.WIDTH(8)) uut (
    .clk(clk), .rst(rst), .pwm_mode(pwm_mode), .level(level), .dout(dout)
  );

  int checks = 0, fails = 0, mism = 0, hn = 0;
  int m_acc = 0, m_cnt = 0, m_sh = 0;
  logic hist [0:1023];
  bit done = 0;

  localparam int NV = 11;
  localparam int V_MODE [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1};
  localparam int V_LVL  [NV] = '{128, 64, 192, 0, 255, 1, 37, 100, 0, 255, 1};
  localparam int V_N    [NV] = '{256, 256, 256, 256, 256, 256, 512, 512, 256, 256, 256};
  localparam int V_ONES [NV] = '{128, 64, 192, 0, 255, 1, 74, 200, 0, 255, 1};

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    int exp_bit;
    #1;
    exp_bit = pwm_mode ? int'(m_cnt < m_sh) : (((m_acc + int'(level)) >> 8) & 1);
    if (!rst) begin
      if (hn < 1024) hist[hn] = dout;
      hn++;
      if (dout !== exp_bit[0]) mism++;
    end
    if (rst) begin
      m_acc = 0; m_cnt = 0; m_sh = int'(level);
    end else begin
      m_acc = (m_acc + int'(level)) & 255;
      if (m_cnt == 255) m_sh = int'(level);
      m_cnt = (m_cnt + 1) & 255;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(bit md, int lv);
    pwm_mode = md; level = 8'(lv); rst = 1'b1;
    tick(); tick();
    rst = 1'b0; hn = 0; mism = 0;
  endtask

  function automatic int ones(int from, int cnt);
    int s = 0;
    for (int k = from; k < from + cnt; k++) s += int'(hist[k]);
    return s;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      int first, bad;
      do_reset(V_MODE[v] != 0, V_LVL[v]);
      for (int c = 0; c < V_N[v]; c++) tick();
      check(mism == 0, V_MODE[v] != 0 ? "R8 per-cycle pwm" : "R7 per-cycle sigma", mism, 0);
      check(ones(0, V_N[v]) == V_ONES[v], V_MODE[v] != 0 ? "R8 high count" : "R2 density",
            ones(0, V_N[v]), V_ONES[v]);
      if (V_LVL[v] == 0) check(ones(0, V_N[v]) == 0, "R6 zero level", ones(0, V_N[v]), 0);
      if (V_MODE[v] == 0 && V_LVL[v] > 0) begin
        first = -1;
        for (int k = V_N[v] - 1; k >= 0; k--) if (hist[k]) first = k;
        check(first + 1 == (256 + V_LVL[v] - 1) / V_LVL[v], "R1 first carry",
              first + 1, (256 + V_LVL[v] - 1) / V_LVL[v]);
      end
      if (V_MODE[v] != 0) begin
        bad = 0;
        for (int k = 0; k < V_N[v]; k++) if (hist[k] != ((k % 256) < V_LVL[v])) bad++;
        check(bad == 0, "R8 pulse shape", bad, 0);
      end
      if (V_MODE[v] == 0 && V_LVL[v] == 128) begin
        bad = 0;
        for (int k = 0; k < V_N[v] - 1; k++) if (hist[k] == hist[k+1]) bad++;
        check(bad == 0, "R3 alternation", bad, 0);
      end
      if (V_MODE[v] == 0 && (V_LVL[v] == 64 || V_LVL[v] == 192)) begin
        bad = 0;
        for (int k = 0; k + 4 <= V_N[v]; k++) if (ones(k, 4) != V_LVL[v] / 64) bad++;
        check(bad == 0, V_LVL[v] == 64 ? "R4 one in four" : "R5 three in four", bad, 0);
      end
    end

    // R9: mid-period level change waits for the next period
    do_reset(1'b1, 50);
    for (int c = 0; c < 100; c++) tick();
    level = 8'd200;
    for (int c = 100; c < 512; c++) tick();
    check(ones(0, 256) == 50, "R9 held period", ones(0, 256), 50);
    check(ones(256, 256) == 200, "R9 next period", ones(256, 256), 200);
    check(mism == 0, "R9 per-cycle", mism, 0);

    // R7: level changes every cycle in sigma mode
    do_reset(1'b0, 11);
    for (int c = 0; c < 400; c++) begin
      level = 8'((c * 53 + 11) & 255);
      tick();
    end
    check(mism == 0, "R7 varying level", mism, 0);

    // R10: mode toggled mid-stream, both paths keep running
    do_reset(1'b0, 77);
    for (int c = 0; c < 600; c++) begin
      if (c % 37 == 0) pwm_mode = ~pwm_mode;
      tick();
    end
    check(mism == 0, "R10 mode switching", mism, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule